// File: doc/BRIEF.md
# Keypad Sequence Lock

This block is a Moore state machine that releases a lock only after a secret sequence of four keys has been entered on a keypad. The keypad is a matrix of three column lines and four row lines, and all seven lines are active-high. A digit counts only after its key has been pressed and then fully let go. Any other input during entry sends the machine back to idle. Once the last digit is released, the lock opens. It stays open while the state register counts on by itself to its highest value, and then it relocks.

The secret digits are parameters. A second sequence can be enabled by a parameter, and then either sequence opens the lock. The current state number is driven onto a 5-bit debug output so that the progress can be watched on LEDs. With a clock of a few hertz, the open window lasts a few seconds.

Top module: `keypad_code_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine goes to state 0 and `unlock` goes to 0 after that edge.
- R2: A key is the 7-bit pattern {col[2:0], row[3:0]} with exactly one col bit and one row bit high. A code is DIGITS such patterns packed together, with digit 0 (the first one entered) in bits [6:0].
- R3: In entry state 2k, the expected digit k moves the machine to state 2k+1. The machine stays in 2k+1 for as long as that key is held.
- R4: In state 2k+1, an all-zero input (key released) moves the machine to 2k+2. In state 2k, an all-zero input leaves the state unchanged.
- R5: In any entry state (below 2*DIGITS), an input that is neither the expected key nor all zero returns the machine to state 0 on the next edge. This includes inputs with several row or column bits high.
- R6: Releasing the last digit leads to state 2*DIGITS. From there the state rises by one on every clock up to 31, and the inputs are ignored. From 31 the next state is 0.
- R7: `unlock` is 1 exactly when the state is 2*DIGITS or higher. It changes on the same edge as the state.
- R8: When ALT_EN is set, the second code also opens the lock. All digits of one attempt must come from the same code, so mixing the two codes never opens the lock.
- R9: `state_dbg` always shows the current state number. No sequence other than a configured code reaches the open states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| col | input | 3 | Keypad column lines, active-high |
| row | input | 4 | Keypad row lines, active-high |
| unlock | output | 1 | Lock open, registered Moore output |
| state_dbg | output | 5 | Current state number |

## Verification
Two functions can fall in the same cycle. The first pair is the return to idle caused by a stray key and the tracking of which code is still live. The bench provokes this with a key that is a valid digit of the other code but not of the code already started. That key must send the machine to idle, not let it advance. The second pair is reset and the self-running open window. The bench asserts reset in the middle of the window and checks that reset wins on that edge. Every cycle is judged against a scoreboard entry computed from the requirements, which gives both the expected state number and the expected `unlock` level.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int COL_W = 3;
  localparam int ROW_W = 4;
  localparam int KEY_W = COL_W + ROW_W;

  typedef logic [KEY_W-1:0] key_t;
endpackage

// File: rtl/lock_digit_match.sv
module lock_digit_match
  import lock_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int IDX_W  = 4,
  parameter logic [DIGITS*KEY_W-1:0] CODE = '0
) (
  input  key_t             key,
  input  logic [IDX_W-1:0] idx,
  output logic             hit
);
  // hit is high when the key equals the digit that idx selects
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      if (idx == IDX_W'(i) && key == CODE[i*KEY_W +: KEY_W]) hit = 1'b1;
    end
  end
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import lock_pkg::*;
#(
  parameter int STATE_W = 5,
  parameter int DIGITS  = 4,
  parameter int NCODES  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  key_t               key,
  input  logic [NCODES-1:0]  hit,
  output logic [STATE_W-1:0] state_o,
  output logic               unlock_o
);
  localparam int OPEN = 2 * DIGITS;
  localparam int LAST = (1 << STATE_W) - 1;

  logic [STATE_W-1:0] st, st_n;
  logic [NCODES-1:0]  live, live_n, cand;
  logic               released;

  always_comb begin
    released = (key == '0);
    cand     = hit & ((st == '0) ? {NCODES{1'b1}} : live);
    st_n     = st;
    live_n   = live;
    if (st >= STATE_W'(OPEN)) begin
      // open window: count on, ignoring the keypad
      st_n = (st == STATE_W'(LAST)) ? '0 : st + 1'b1;
    end else if (!st[0]) begin
      // waiting for a press
      if (|cand) begin
        st_n   = st + 1'b1;
        live_n = cand;
      end else if (!released) begin
        st_n = '0;
      end
    end else begin
      // key down, waiting for the release
      if (|cand)         st_n = st;
      else if (released) st_n = st + 1'b1;
      else               st_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= '0;
      live     <= {NCODES{1'b1}};
      unlock_o <= 1'b0;
    end else begin
      st       <= st_n;
      live     <= live_n;
      unlock_o <= (st_n >= STATE_W'(OPEN));
    end
  end

  assign state_o = st;
endmodule

// File: rtl/keypad_code_lock.sv
module keypad_code_lock
  import lock_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter int STATE_W = 5,
  parameter bit ALT_EN  = 1'b0,
  parameter logic [DIGITS*KEY_W-1:0] CODE_A = {7'b010_0100, 7'b001_0010, 7'b100_0001, 7'b100_1000},
  parameter logic [DIGITS*KEY_W-1:0] CODE_B = {7'b001_1000, 7'b100_0001, 7'b010_0010, 7'b010_0010}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COL_W-1:0]   col,
  input  logic [ROW_W-1:0]   row,
  output logic               unlock,
  output logic [STATE_W-1:0] state_dbg
);
  localparam int NCODES = ALT_EN ? 2 : 1;
  localparam int IDX_W  = STATE_W - 1;

  key_t               key;
  logic [NCODES-1:0]  hit;
  logic [STATE_W-1:0] st;

  assign key = {col, row};

  for (genvar g = 0; g < NCODES; g++) begin : g_code
    lock_digit_match #(
      .DIGITS(DIGITS),
      .IDX_W (IDX_W),
      .CODE  ((g == 0) ? CODE_A : CODE_B)
    ) u_match (
      .key(key),
      .idx(st[STATE_W-1:1]),
      .hit(hit[g])
    );
  end

  lock_seq_fsm #(
    .STATE_W(STATE_W),
    .DIGITS (DIGITS),
    .NCODES (NCODES)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .key     (key),
    .hit     (hit),
    .state_o (st),
    .unlock_o(unlock)
  );

  assign state_dbg = st;
endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int DIGITS  = 4,
  parameter int STATE_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         col,
  input logic [3:0]         row,
  input logic [STATE_W-1:0] state_dbg,
  input logic               unlock
);
  localparam int OPEN = 2 * DIGITS;
  localparam int LAST = (1 << STATE_W) - 1;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state_dbg == '0 && !unlock));

  a_r5_stray_to_idle: assert property (@(posedge clk) disable iff (rst)
    (state_dbg < STATE_W'(OPEN) && {col, row} != '0 &&
     ($countones(col) != 1 || $countones(row) != 1)) |=> state_dbg == '0);

  a_r4_release_advances: assert property (@(posedge clk) disable iff (rst)
    (state_dbg < STATE_W'(OPEN) && state_dbg[0] && {col, row} == '0)
      |=> state_dbg == STATE_W'($past(state_dbg) + 1'b1));

  a_r6_window_counts: assert property (@(posedge clk) disable iff (rst)
    (state_dbg >= STATE_W'(OPEN) && state_dbg != STATE_W'(LAST))
      |=> state_dbg == STATE_W'($past(state_dbg) + 1'b1));

  a_r6_window_wraps: assert property (@(posedge clk) disable iff (rst)
    (state_dbg == STATE_W'(LAST)) |=> state_dbg == '0);

  a_r7_unlock_level: assert property (@(posedge clk) disable iff (rst)
    unlock == (state_dbg >= STATE_W'(OPEN)));

  a_r9_open_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> $past(state_dbg) == STATE_W'(OPEN - 1));
endmodule

bind keypad_code_lock lock_checker #(
  .DIGITS (DIGITS),
  .STATE_W(STATE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .col      (col),
  .row      (row),
  .state_dbg(state_dbg),
  .unlock   (unlock)
);

// File: tb/tb_keypad_code_lock.sv
module tb_keypad_code_lock;
  typedef struct {
    int    q;
    bit    u;
    string tag;
  } exp_t;

  function automatic logic [6:0] kp(input int c, input int r);
    return {3'(1 << c), 4'(1 << r)};
  endfunction

  localparam logic [6:0] A0 = 7'b100_1000, A1 = 7'b001_0010, A2 = 7'b010_0001, A3 = 7'b100_0100;
  localparam logic [6:0] B0 = 7'b010_0010, B1 = 7'b001_0010, B2 = 7'b100_0001, B3 = 7'b001_1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] col = '0;
  logic [3:0] row = '0;
  logic       unlock;
  logic [4:0] state_dbg;

  int checks = 0, failures = 0, opens = 0;
  bit done = 1'b0;
  exp_t sb[$];

  logic [6:0] codes [2][4];
  int  m_state = 0;
  logic [1:0] m_cand = 2'b11;

  keypad_code_lock #(
    .DIGITS(4), .STATE_W(5), .ALT_EN(1'b1),
    .CODE_A({A3, A2, A1, A0}),
    .CODE_B({B3, B2, B1, B0})
  ) dut (
    .clk(clk), .rst(rst), .col(col), .row(row),
    .unlock(unlock), .state_dbg(state_dbg)
  );

  always #10 clk = ~clk;

  // requirement-level model of the next state
  function automatic void model(input bit r, input logic [6:0] k);
    logic [1:0] live, h;
    int pos;
    if (r) begin
      m_state = 0; m_cand = 2'b11; return;
    end
    if (m_state >= 8) begin
      m_state = (m_state == 31) ? 0 : m_state + 1; return;
    end
    pos  = m_state / 2;
    live = (m_state == 0) ? 2'b11 : m_cand;
    for (int c = 0; c < 2; c++) h[c] = live[c] && (k == codes[c][pos]);
    if (m_state % 2 == 0) begin
      if (|h) begin m_state++; m_cand = h; end
      else if (k != 0) m_state = 0;
    end else begin
      if (|h) m_state = m_state;
      else if (k == 0) m_state++;
      else m_state = 0;
    end
  endfunction

  task automatic drive(input bit r, input logic [6:0] k, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; col = k[6:4]; row = k[3:0];
    model(r, k);
    e.q = m_state; e.u = (m_state >= 8); e.tag = tag;
    if (e.u && e.q == 8) opens++;
    sb.push_back(e);
  endtask

  task automatic digit(input logic [6:0] k, input int hold, input int gap, input string tag);
    for (int i = 0; i < hold; i++) drive(1'b0, k, tag);
    for (int i = 0; i < gap; i++) drive(1'b0, 7'd0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, kp(i % 3, i % 4) | 7'b000_0001, tag);
  endtask

  task automatic settle();
    for (int i = 0; i < 30; i++) drive(1'b0, 7'd0, "R6");
    drive(1'b1, 7'd0, "R1");
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (state_dbg !== 5'(e.q) || unlock !== e.u) begin
          failures++;
          $display("FAIL %s state=%0d exp=%0d unlock=%0b exp=%0b", e.tag, state_dbg, e.q, unlock, e.u);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int exp_opens;
    codes[0][0] = A0; codes[0][1] = A1; codes[0][2] = A2; codes[0][3] = A3;
    codes[1][0] = B0; codes[1][1] = B1; codes[1][2] = B2; codes[1][3] = B3;
    exp_opens = 0;

    // R1: reset with keys present
    drive(1'b1, A0, "R1"); drive(1'b1, 7'h7F, "R1"); drive(1'b1, 7'd0, "R1");

    // R2 R3 R4 R6 R7 R9: code A, varied holds, gaps and noisy window
    digit(A0, 1, 1, "R3"); digit(A1, 4, 3, "R3"); digit(A2, 2, 1, "R4"); digit(A3, 3, 1, "R4");
    exp_opens++;
    idle(26, "R6");   // inputs ignored through 31 and wrap to 0

    // R8: second code opens
    digit(B0, 2, 2, "R8"); digit(B1, 1, 1, "R8"); digit(B2, 1, 1, "R8"); digit(B3, 2, 1, "R8");
    exp_opens++;
    settle();

    // R8: mixing codes never opens (A0, shared digit, then B2, B3)
    digit(A0, 1, 1, "R8"); digit(A1, 1, 1, "R8"); digit(B2, 1, 1, "R8"); digit(B3, 1, 1, "R8");
    drive(1'b1, 7'd0, "R1");

    // R5: multi-key presses in press and held states
    digit(A0, 1, 1, "R5"); drive(1'b0, A1 | kp(0, 3), "R5");
    digit(A0, 2, 0, "R5"); drive(1'b0, 7'b011_1000, "R5");
    digit(A0, 1, 1, "R5"); digit(A1, 1, 0, "R5"); drive(1'b0, A2, "R5"); drive(1'b0, 7'd0, "R5");

    // R9: every wrong key at every position of code A
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 3; c++) begin
        for (int r = 0; r < 4; r++) begin
          if (kp(c, r) == codes[0][p]) continue;
          for (int j = 0; j < p; j++) digit(codes[0][j], 1, 1, "R9");
          digit(kp(c, r), 1, 1, "R9");
          for (int j = p + 1; j < 4; j++) digit(codes[0][j], 1, 1, "R9");
          drive(1'b1, 7'd0, "R1");
        end
      end
    end

    // R1 over R6: reset in the middle of the open window
    digit(A0, 1, 1, "R1"); digit(A1, 1, 1, "R1"); digit(A2, 1, 1, "R1"); digit(A3, 1, 1, "R1");
    exp_opens++;
    idle(5, "R6");
    drive(1'b1, A0, "R1");
    drive(1'b0, 7'd0, "R1");

    repeat (3) @(negedge clk);
    checks++;
    if (opens != exp_opens) begin
      failures++;
      $display("FAIL R9 opens=%0d exp=%0d", opens, exp_opens);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule